// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The controller observes 19 asynchronous external input lines. Each line is brought into the clock domain through a two-flop synchronizer. It is then compared with its value from one cycle earlier to find rising and falling transitions. Per-line select bits choose which transitions count, and a selected transition latches a pending flag. Pending flags that are also enabled by the interrupt mask drive a set of request outputs. Lines 0 to 4 each have their own request. Lines 5 to 9 share one request, lines 10 to 15 share another, and lines 16 to 18 each have their own.

Software reaches six 32-bit registers through a simple word-addressed bus: interrupt mask, event mask, rising select, falling select, software trigger and pending. Writes take effect on the clock edge. Reads return the addressed register combinationally. Pending flags are cleared by writing one. Software can also raise a line's pending flag itself. A separate per-line event pulse output fires for one cycle on each selected transition of a line whose event mask bit is set.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register reads 0 and irq_o and evt_o are all 0.
- R2: Word offsets 0..5 select the interrupt mask, event mask, rising select, falling select, software trigger and pending registers. Bit n of each belongs to line n. For offsets 0..3 a write stores bits 18:0 and bits 31:19 read 0. Offsets 6 and 7 read 0.
- R3: When line n goes from 0 to 1 and its rising select bit is 1, pending bit n reads 1 from the third clock edge after the change. With the rising select bit at 0, a rising transition leaves the pending bit at 0.
- R4: A 1-to-0 transition sets pending bit n only when its falling select bit is 1. With both select bits at 1, either transition sets it.
- R5: Writing 1 to pending bit n (offset 5) clears it. A written 0 leaves the bit unchanged.
- R6: A request output is 1 only while at least one of its lines has both its pending bit and its interrupt mask bit at 1. Clearing the mask bit drops a dedicated request on the clock edge of the write.
- R7: Request mapping: lines 0..4 drive irq_o[0..4], the OR of lines 5..9 drives irq_o[5], the OR of lines 10..15 drives irq_o[6], and lines 16..18 drive irq_o[7..9].
- R8: Writing 1 to software trigger bit n (offset 4) sets that bit and pending bit n. The trigger bit then reads 1 until pending bit n is cleared, at which point it reads 0. Writing 0 to a trigger bit has no effect.
- R9: If a selected transition is detected in the same cycle as a write-one clear of that line's pending bit, the pending bit stays 1.
- R10: evt_o[n] is 1 for exactly the one cycle in which a selected transition of line n is detected, provided event mask bit n is 1. With event mask bit n at 0, evt_o[n] stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 19 | External input lines, asynchronous |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when 1 (with bus_en_i) |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 10 | Interrupt request outputs |
| evt_o | output | 19 | One-cycle event pulses per line |

## Verification
The hardest situation to create is a detected transition that lands in the same cycle as a software clear of that line's pending flag. The synchronizer latency has to be counted exactly for the two to coincide. The bench first raises the line's pending bit with a software trigger. It then changes the input at a falling clock edge, waits two rising edges, and issues the clear so that the write is captured on the third edge, which is the edge that also sets the flag. The shared request groups are exercised by setting two lines of one group and clearing them one at a time.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned NUM_LINES  = 19;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 3;
  // lines below DED_END get own request; then two shared groups
  localparam int unsigned DED_END    = 5;
  localparam int unsigned GRP_A_END  = 10;
  localparam int unsigned GRP_B_END  = 16;
  localparam int unsigned NUM_REQ    = DED_END + 2 + (NUM_LINES - GRP_B_END);

  typedef enum logic [ADDR_W-1:0] {
    OFF_IMASK  = 3'd0,
    OFF_EMASK  = 3'd1,
    OFF_RISE   = 3'd2,
    OFF_FALL   = 3'd3,
    OFF_SWTRIG = 3'd4,
    OFF_PEND   = 3'd5,
    OFF_RSV6   = 3'd6,
    OFF_RSV7   = 3'd7
  } reg_off_e;

  function automatic int line_req(input int l);
    if (l < int'(DED_END))        return l;
    else if (l < int'(GRP_A_END)) return int'(DED_END);
    else if (l < int'(GRP_B_END)) return int'(DED_END) + 1;
    else                          return l - int'(GRP_B_END) + int'(DED_END) + 2;
  endfunction
endpackage

// File: rtl/extint_edge_det.sv
module extint_edge_det #(
  parameter int unsigned N = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= line_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[i] = s2_q & ~s3_q;
    assign fall_o[i] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/extint_reg_bank.sv
module extint_reg_bank
  import extint_pkg::*;
#(
  parameter int unsigned N = NUM_LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N-1:0]      rise_i,
  input  logic [N-1:0]      fall_i,
  output logic [N-1:0]      hit_o,
  output logic [N-1:0]      imask_o,
  output logic [N-1:0]      emask_o,
  output logic [N-1:0]      swt_o,
  output logic [N-1:0]      pend_o
);
  logic [N-1:0] imask_q, emask_q, rsel_q, fsel_q, swt_q, pend_q;
  logic [N-1:0] wbits, sw_set, pclr, pset, pclr_eff;
  logic         wr;
  reg_off_e     off;

  assign off   = reg_off_e'(bus_addr_i);
  assign wr    = bus_en_i & bus_we_i;
  assign wbits = bus_wdata_i[N-1:0];

  always_comb begin
    hit_o    = (rise_i & rsel_q) | (fall_i & fsel_q);
    sw_set   = (wr && off == OFF_SWTRIG) ? wbits : '0;
    pclr     = (wr && off == OFF_PEND) ? wbits : '0;
    pset     = hit_o | sw_set;
    pclr_eff = pclr & ~pset;  // new event wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rsel_q  <= '0;
      fsel_q  <= '0;
      swt_q   <= '0;
      pend_q  <= '0;
    end else begin
      if (wr && off == OFF_IMASK) imask_q <= wbits;
      if (wr && off == OFF_EMASK) emask_q <= wbits;
      if (wr && off == OFF_RISE)  rsel_q  <= wbits;
      if (wr && off == OFF_FALL)  fsel_q  <= wbits;
      swt_q  <= (swt_q & ~pclr_eff) | sw_set;
      pend_q <= (pend_q & ~pclr_eff) | pset;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (off)
      OFF_IMASK:  bus_rdata_o[N-1:0] = imask_q;
      OFF_EMASK:  bus_rdata_o[N-1:0] = emask_q;
      OFF_RISE:   bus_rdata_o[N-1:0] = rsel_q;
      OFF_FALL:   bus_rdata_o[N-1:0] = fsel_q;
      OFF_SWTRIG: bus_rdata_o[N-1:0] = swt_q;
      OFF_PEND:   bus_rdata_o[N-1:0] = pend_q;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign swt_o   = swt_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/extint_req_map.sv
module extint_req_map
  import extint_pkg::*;
#(
  parameter int unsigned N = NUM_LINES,
  parameter int unsigned R = NUM_REQ
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] imask_i,
  output logic [R-1:0] irq_o
);
  logic [N-1:0] act;
  assign act = pend_i & imask_i;

  always_comb begin
    irq_o = '0;
    for (int k = 0; k < int'(R); k++) begin
      for (int l = 0; l < int'(N); l++) begin
        if (line_req(l) == k) irq_o[k] = irq_o[k] | act[l];
      end
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 bus_en_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_REQ-1:0]   irq_o,
  output logic [NUM_LINES-1:0] evt_o
);
  logic [NUM_LINES-1:0] rise, fall, hit, imask, emask, swt, pend;

  extint_edge_det #(.N(NUM_LINES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  extint_reg_bank #(.N(NUM_LINES)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .rise_i      (rise),
    .fall_i      (fall),
    .hit_o       (hit),
    .imask_o     (imask),
    .emask_o     (emask),
    .swt_o       (swt),
    .pend_o      (pend)
  );

  extint_req_map #(.N(NUM_LINES), .R(NUM_REQ)) u_map (
    .pend_i  (pend),
    .imask_i (imask),
    .irq_o   (irq_o)
  );

  assign evt_o = hit & emask;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
  import extint_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_en_i,
  input logic                 bus_we_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [DATA_W-1:0]    bus_rdata_o,
  input logic [NUM_REQ-1:0]   irq_o,
  input logic [NUM_LINES-1:0] evt_o,
  input logic [NUM_LINES-1:0] pend_i,
  input logic [NUM_LINES-1:0] imask_i,
  input logic [NUM_LINES-1:0] emask_i,
  input logic [NUM_LINES-1:0] swt_i
);
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:NUM_LINES] == '0); // R2

  AST_PEND_DROP_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_i) & ~pend_i) != '0) |->
      ($past(bus_en_i) && $past(bus_we_i) && $past(bus_addr_i) == 3'd5)); // R5

  AST_REQ_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & imask_i) == '0) |-> (irq_o == '0)); // R6

  AST_SWT_IMPLIES_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swt_i & ~pend_i) == '0); // R8

  AST_EVT_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |=> (($past(evt_o) & ~pend_i) == '0)); // R9

  AST_EVT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o & ~emask_i) == '0); // R10
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .evt_o       (evt_o),
  .pend_i      (pend),
  .imask_i     (imask),
  .emask_i     (emask),
  .swt_i       (swt)
);

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;
  import extint_pkg::*;

  localparam logic [31:0] ALL = 32'h0007_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] line = '0;
  logic        en = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [9:0]  irq;
  logic [18:0] evt;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  extint_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .evt_o(evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int req_of(input int l);
    if (l < 5) return l;
    if (l < 10) return 5;
    if (l < 16) return 6;
    return l - 9;
  endfunction

  // [8:4] line, [3] rise sel, [2] fall sel, [1] drive rising edge, [0] expect pending
  localparam logic [8:0] VEC [10] = '{
    {5'd0,  1'b1, 1'b0, 1'b1, 1'b1},
    {5'd3,  1'b0, 1'b1, 1'b0, 1'b1},
    {5'd7,  1'b1, 1'b1, 1'b1, 1'b1},
    {5'd7,  1'b1, 1'b1, 1'b0, 1'b1},
    {5'd12, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd15, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd16, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd18, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd9,  1'b0, 1'b0, 1'b1, 1'b0},
    {5'd11, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reg", d, 32'h0);
    end
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 evt", 32'(evt), 32'h0);

    // R2 readback and reserved offsets
    for (int a = 0; a < 4; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), d);
      check("R2 readback", d, ALL);
      wr(3'(a), 32'h0);
    end
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R2 offset6", d, 32'h0);
    rd(3'd7, d); check("R2 offset7", d, 32'h0);

    // vector table: R3 R4 R7
    wr(OFF_IMASK, ALL);
    foreach (VEC[i]) begin
      int l;
      logic [31:0] bit_l;
      l = int'(VEC[i][8:4]);
      bit_l = 32'h1 << l;
      wr(OFF_RISE, VEC[i][3] ? bit_l : 32'h0);
      wr(OFF_FALL, VEC[i][2] ? bit_l : 32'h0);
      @(negedge clk) line = VEC[i][1] ? 19'h0 : 19'(bit_l);
      wait_cyc(4);
      wr(OFF_PEND, ALL);
      @(negedge clk) line = VEC[i][1] ? 19'(bit_l) : 19'h0;
      wait_cyc(4);
      rd(OFF_PEND, d);
      check("R3/R4 pending", d, VEC[i][0] ? bit_l : 32'h0);
      check("R7 request", 32'(irq), VEC[i][0] ? (32'h1 << req_of(l)) : 32'h0);
    end
    wr(OFF_RISE, 32'h0); wr(OFF_FALL, 32'h0);
    @(negedge clk) line = '0;
    wait_cyc(4);
    wr(OFF_PEND, ALL);

    // R3 exact latency: visible after third edge, not after second
    wr(OFF_RISE, 32'h1);
    @(negedge clk) line = 19'h1;
    wait_cyc(2);
    rd(OFF_PEND, d); check("R3 not yet", d, 32'h0);
    rd(OFF_PEND, d); check("R3 third edge", d, 32'h1);

    // R5 write zero no effect, write one clears only that bit
    wr(OFF_SWTRIG, 32'h0000_0404);  // lines 2 and 10
    wr(OFF_PEND, 32'h0);
    rd(OFF_PEND, d); check("R5 write0", d, 32'h0000_0405);
    wr(OFF_PEND, 32'h0000_0400);
    rd(OFF_PEND, d); check("R5 write1", d, 32'h0000_0005);

    // R6 mask gating
    check("R6 irq on", 32'(irq), 32'h0000_0005);
    wr(OFF_IMASK, ALL & ~32'h4);
    check("R6 mask off", 32'(irq), 32'h0000_0001);
    wr(OFF_PEND, ALL);
    wr(OFF_IMASK, ALL);
    wr(OFF_RISE, 32'h0);

    // R7 shared group 5..9
    wr(OFF_SWTRIG, 32'h0000_0220);
    check("R7 group both", 32'(irq), 32'h0000_0020);
    wr(OFF_PEND, 32'h0000_0020);
    check("R7 group one left", 32'(irq), 32'h0000_0020);
    wr(OFF_PEND, 32'h0000_0200);
    check("R7 group clear", 32'(irq), 32'h0);

    // R8 software trigger
    wr(OFF_SWTRIG, 32'h0000_0010);
    rd(OFF_SWTRIG, d); check("R8 trig bit", d, 32'h0000_0010);
    rd(OFF_PEND, d);   check("R8 pend set", d, 32'h0000_0010);
    wr(OFF_SWTRIG, 32'h0);
    rd(OFF_SWTRIG, d); check("R8 write0", d, 32'h0000_0010);
    wr(OFF_PEND, 32'h0000_0010);
    rd(OFF_SWTRIG, d); check("R8 self clear", d, 32'h0);

    // R9 edge coincident with clear
    @(negedge clk) line = '0;
    wait_cyc(4);
    wr(OFF_PEND, ALL);
    wr(OFF_RISE, 32'h2);
    wr(OFF_SWTRIG, 32'h2);
    @(negedge clk) line = 19'h2;
    wait_cyc(2);
    wr(OFF_PEND, 32'h2);
    rd(OFF_PEND, d); check("R9 set wins", d, 32'h2);
    wr(OFF_PEND, ALL);
    rd(OFF_PEND, d); check("R9 later clear", d, 32'h0);

    // R10 event pulse
    wr(OFF_EMASK, 32'h0000_0008);
    wr(OFF_RISE, 32'h0000_0048);
    @(negedge clk) line = 19'h0000_004A;
    wait_cyc(2);
    @(negedge clk);
    check("R10 pulse", 32'(evt), 32'h0000_0008);
    @(negedge clk);
    check("R10 one cycle", 32'(evt), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule